// File: doc/BRIEF.md
# Segmented Log-PCM Successive-Approximation Controller

This block sequences the digital half of a companding analog-to-digital converter. Each time the 8 kHz sample strobe arrives while the block is idle, it runs a bit-serial successive-approximation search. Every cycle it presents a trial code to an external DAC and comparator pair and reads back one comparator bit. The sign is decided first. The three chord bits follow, and then the four step bits inside the chosen chord. The finished 8-bit word is then latched and flagged with a one-cycle done pulse.

Alongside the search, the decided sign of every finished word feeds a saturating signed integrator. Its value stands in for the control level of a DC-offset auto-zero loop. A steady run of positive samples drives it up and a steady run of negative samples drives it down. The analog array, the comparator and any filtering are outside the block, and the testbench models them.

Top module: `pcm_sar_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, conv_done, pcm_word, trial_code and offset_acc are all cleared to zero.
- R2: A sample_strobe sampled high at an edge while idle starts a conversion. After that edge, trial_code is 8'h80: only the sign trial bit is set.
- R3: Decision j (j = 0..7) tests bit 7-j. During decision j, trial_code holds the bits already decided above bit 7-j, a 1 at bit 7-j, and zeros below it. At each decision edge the tested bit keeps the comparator value (comp_ge = 1 means the input is at or above the trial level).
- R4: The finished word has the sign in bit 7 (1 = input at or above zero), the chord in bits 6..4 and the step in bits 3..0. It equals the code found by the search.
- R5: conv_done is high for exactly one cycle. It rises at the ninth clock edge after the edge that accepted the strobe: eight decision edges, then one latch edge.
- R6: A sample_strobe sampled at any edge from the first decision edge through the latch edge is ignored. It starts no conversion and causes no extra done pulse.
- R7: At the latch edge, offset_acc rises by 1 if the new sign bit is 1 and falls by 1 if it is 0. Between conversions it does not change.
- R8: offset_acc saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1) and never wraps.
- R9: pcm_word keeps its value from one latch edge until the next. During the done cycle it equals trial_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_strobe | input | 1 | Sample request, one per 125 µs frame |
| comp_ge | input | 1 | Comparator result: input at or above trial level |
| trial_code | output | WORD_W | Trial code driven to the external DAC |
| conv_done | output | 1 | One-cycle pulse when pcm_word is new |
| pcm_word | output | WORD_W | Finished sign/chord/step word |
| offset_acc | output | ACC_W | Signed saturating sign integral |

## Verification
The embedded assertions check the following on every cycle: done lasts a single cycle, the word stays stable outside latch edges, the word matches the trial register while done is high, the integrator moves by at most one and only at a latch edge, it holds at both rails, and a running conversion is never dropped back to idle. Only the bench's scenarios can show the rest. These are the exact trial code sequence of a search, a correct final word for many input patterns, the edge on which done lands, strobes ignored during a conversion, and the integrator reaching each rail after a run of same-signed samples.

// File: rtl/pcm_sar_pkg.sv
// Shared types for the log-PCM successive-approximation controller.
package pcm_sar_pkg;
    // Conversion sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_LATCH = 2'd2
    } sar_state_t;
endpackage

// File: rtl/sar_sequencer.sv
// Conversion sequencer: accepts a strobe only when idle, walks the bit
// index from the top bit down to zero (one comparator decision per cycle),
// then spends one cycle in the latch state. Assumes strobe is synchronous.
module sar_sequencer
    import pcm_sar_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic             start,
    output logic             decide,
    output logic             latch,
    output logic [IDX_W-1:0] bit_idx
);
    sar_state_t state;

    // Strobe is honoured only in idle; elsewhere it is dropped.
    assign start  = (state == ST_IDLE) && strobe;
    assign decide = (state == ST_CONV);
    assign latch  = (state == ST_LATCH);

    // State and bit-index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (strobe) begin
                    state   <= ST_CONV;
                    bit_idx <= IDX_W'(WORD_W - 1);
                end
                ST_CONV: if (bit_idx == '0) state <= ST_LATCH;
                         else bit_idx <= bit_idx - 1'b1;
                ST_LATCH: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    conv_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |=> (state != ST_IDLE));

    // R5
    latch_follows_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && bit_idx == '0) |=> (state == ST_LATCH));
endmodule

// File: rtl/sar_register.sv
// Successive-approximation register: on start it loads a lone top trial
// bit. On each decision it keeps the comparator value in the tested bit
// and raises the next lower trial bit. On latch it copies the trial
// register to the output word and pulses done.
module sar_register #(
    parameter int WORD_W = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              decide,
    input  logic              latch,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              comp,
    output logic [WORD_W-1:0] trial,
    output logic [WORD_W-1:0] word,
    output logic              done
);
    logic [WORD_W-1:0] trial_nxt;

    // Per-bit next value for one decision step.
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            if (i == int'(bit_idx))
                trial_nxt[i] = comp;
            else if (bit_idx != '0 && i == int'(bit_idx) - 1)
                trial_nxt[i] = 1'b1;
            else
                trial_nxt[i] = trial[i];
        end
    end

    // Trial register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trial <= '0;
        else if (start)
            trial <= {1'b1, {(WORD_W-1){1'b0}}};
        else if (decide)
            trial <= trial_nxt;
    end

    // Output word and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            done <= 1'b0;
        end else begin
            done <= latch;
            if (latch) word <= trial;
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(word));

    // R3
    decided_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && bit_idx == IDX_W'(WORD_W - 1)) |=> trial[WORD_W-1] == $past(comp));
endmodule

// File: rtl/offset_integrator.sv
// Saturating signed integrator of decided sign bits: +1 for a positive
// sign and -1 for a negative sign, applied once per finished conversion.
module offset_integrator #(
    parameter int ACC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    update,
    input  logic                    sign_pos,
    output logic signed [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // Accumulate with clamping at both rails.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (update) begin
            if (sign_pos && acc != ACC_MAX)
                acc <= acc + 1'b1;
            else if (!sign_pos && acc != ACC_MIN)
                acc <= acc - 1'b1;
        end
    end

    // R7
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(acc));

    // R8
    no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update && sign_pos && acc == ACC_MAX) |=> acc == ACC_MAX);

    // R8
    no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !sign_pos && acc == ACC_MIN) |=> acc == ACC_MIN);
endmodule

// File: rtl/pcm_sar_ctrl.sv
// Top of the log-PCM successive-approximation controller. Wires the
// sequencer, the approximation register and the sign integrator. Assumes
// a comparator that settles within one clock of a trial code change.
module pcm_sar_ctrl #(
    parameter int WORD_W = 8,
    parameter int ACC_W  = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_strobe,
    input  logic                    comp_ge,
    output logic [WORD_W-1:0]       trial_code,
    output logic                    conv_done,
    output logic [WORD_W-1:0]       pcm_word,
    output logic signed [ACC_W-1:0] offset_acc
);
    logic             start, decide, latch;
    logic [IDX_W-1:0] bit_idx;

    sar_sequencer #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe(sample_strobe),
        .start(start), .decide(decide), .latch(latch), .bit_idx(bit_idx)
    );

    sar_register #(.WORD_W(WORD_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .start(start), .decide(decide),
        .latch(latch), .bit_idx(bit_idx), .comp(comp_ge),
        .trial(trial_code), .word(pcm_word), .done(conv_done)
    );

    offset_integrator #(.ACC_W(ACC_W)) u_int (
        .clk(clk), .rst_n(rst_n), .update(latch),
        .sign_pos(trial_code[WORD_W-1]), .acc(offset_acc)
    );

    // R9
    word_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (pcm_word == trial_code));

    // R7
    acc_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_acc != $past(offset_acc)) |-> conv_done);
endmodule

// File: tb/tb_pcm_sar_ctrl.sv
// Scoreboard bench: the driver models the comparator from a target code,
// pushes the expected word and integrator value, and a monitor pops and
// compares them on every done pulse.
module tb_pcm_sar_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_W = 4;
    localparam int ACC_MAX = 7;
    localparam int ACC_MIN = -8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_strobe = 1'b0;
    logic comp_ge = 1'b0;
    logic [7:0] trial_code, pcm_word;
    logic conv_done;
    logic signed [ACC_W-1:0] offset_acc;

    int n_chk = 0, n_fail = 0;
    int exp_acc = 0;
    int n_done = 0;
    bit finished = 0;

    typedef struct { logic [7:0] word; int acc; } exp_t;
    exp_t sb_q[$];

    pcm_sar_ctrl #(.WORD_W(8), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
        .comp_ge(comp_ge), .trial_code(trial_code), .conv_done(conv_done),
        .pcm_word(pcm_word), .offset_acc(offset_acc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare every done pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && conv_done) begin
            n_done++;
            if (sb_q.size() == 0) begin
                chk(0, "R6 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(pcm_word == e.word, "R4 word", pcm_word, e.word);
                chk(int'(offset_acc) == e.acc, "R7/R8 offset_acc", offset_acc, e.acc);
            end
        end
    end

    // Driver: one conversion of target t; hold strobe high through the
    // busy window when spam is set.
    task automatic convert(input logic [7:0] t, input bit spam);
        exp_t e;
        int d0;
        logic [7:0] exp_tr;
        if (t[7]) exp_acc = (exp_acc < ACC_MAX) ? exp_acc + 1 : ACC_MAX;
        else      exp_acc = (exp_acc > ACC_MIN) ? exp_acc - 1 : ACC_MIN;
        e.word = t; e.acc = exp_acc;
        sb_q.push_back(e);
        d0 = n_done;
        @(negedge clk);
        sample_strobe = 1'b1;
        for (int j = 0; j <= 12; j++) begin
            @(negedge clk);
            sample_strobe = spam && (j >= 1) && (j <= 7);
            if (j <= 7) begin
                exp_tr = (t & ~(8'hFF >> j)) | (8'h80 >> j);
                // R2 / R3: trial code of decision j
                chk(trial_code == exp_tr, j == 0 ? "R2 first trial" : "R3 trial",
                    trial_code, exp_tr);
                comp_ge = (j == 0) ? t[7] : (t[6:0] >= trial_code[6:0]);
            end
            if (j == 8) chk(conv_done == 1'b0, "R5 done early", conv_done, 0);
            if (j == 9) chk(conv_done == 1'b1, "R5 done edge", conv_done, 1);
            if (j == 12) begin
                chk(pcm_word == t, "R9 word held", pcm_word, t);
                chk(n_done == d0 + 1, "R6 one done", n_done, d0 + 1);
                chk(trial_code == t, "R6 no restart", trial_code, t);
            end
        end
        sample_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(conv_done == 0, "R1 done", conv_done, 0);
        chk(pcm_word == 0, "R1 word", pcm_word, 0);
        chk(trial_code == 0, "R1 trial", trial_code, 0);
        chk(offset_acc == 0, "R1 acc", offset_acc, 0);
        rst_n = 1'b1;
        @(negedge clk);

        convert(8'hA5, 0);
        convert(8'h00, 0);
        convert(8'hFF, 0);
        convert(8'h80, 0);
        convert(8'h7F, 0);
        convert(8'h3C, 1);   // R6 strobe spam
        convert(8'hD1, 1);
        for (int k = 0; k < 16; k++) convert(8'(k * 37 + 11), k[0]);

        // R8: drive to upper rail, then to lower rail
        for (int k = 0; k < 10; k++) convert(8'h80 | 8'(k * 9), 0);
        chk(int'(offset_acc) == ACC_MAX, "R8 upper rail", offset_acc, ACC_MAX);
        for (int k = 0; k < 20; k++) convert(8'(k * 5), 0);
        chk(int'(offset_acc) == ACC_MIN, "R8 lower rail", offset_acc, ACC_MIN);
        convert(8'h81, 0);
        chk(int'(offset_acc) == ACC_MIN + 1, "R7 step off rail", offset_acc, ACC_MIN + 1);

        // R7: no change between conversions
        repeat (20) @(negedge clk);
        chk(int'(offset_acc) == ACC_MIN + 1, "R7 idle hold", offset_acc, ACC_MIN + 1);
        chk(sb_q.size() == 0, "R5 missing done", sb_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule